// File: doc/BRIEF.md
# Depth/Width Prefetch Candidate Generator

This block turns one cache-miss event on a trained stride stream into a burst of prefetch block addresses. The total number of addresses per event is bounded by a fixed prefetch degree. It first works in depth on the stream that missed. How many addresses it takes there, and whether it jumps ahead of the miss first, depends on the stream's time-interval class, measured in misses between accesses.

Budget left over is spent in width. The generator walks a time-ordered chain of next-stream pointers held in the stream table and applies the same per-class quota to every linked stream that is trained and was touched recently. When the chain ends while budget remains, the walk starts again at the triggering stream. Each stream continues from where it stopped earlier in the same event.

The stream table lives outside this block and is not written by it. The generator drives a table index and reads the selected entry combinationally. Prefetch addresses leave one per cycle on a valid/ready stream. A one-cycle done pulse closes every event.

Top module: `dw_prefetch_gen`

## Requirements
- R1: After reset the generator is idle: `trig_ready` is 1, and `pf_valid` and `done` are 0.
- R2: No event emits more than DEGREE (default 8) addresses. An event whose triggering stream is ready emits exactly DEGREE addresses.
- R3: A stream of class short (code 0), on its first visit in an event, starts at k = 3, skipping two stride blocks. It takes all of the remaining budget.
- R4: A stream of class medium (code 1) starts without a skip and emits DEGREE/2 addresses per visit, capped by the remaining budget.
- R5: Per visit, a stream of class long (code 2) emits DEGREE/4 addresses and a stream of class very-long (code 3) emits exactly one, both capped by the remaining budget.
- R6: A linked stream contributes only if all three hold: its confidence is at least 2, its stride is nonzero, and the current miss time minus its last-access time is at most 20 (modulo the time width). An age of 20 qualifies and an age of 21 does not.
- R7: When the chain ends (link-valid bit 0) with budget left, the walk returns to the triggering stream. Every stream then resumes at the step after the last one it emitted in this event, and the skip is never applied again.
- R8: Each address equals the stream's last address plus k times its stride, with k counting up by one per emitted address of that stream.
- R9: A trigger on a stream whose confidence is below 2 or whose stride is zero emits no address and still ends with a done pulse.
- R10: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_addr` holds its value. At most one address transfers per cycle.
- R11: `done` lasts one cycle and is followed by the idle state. `trig_ready` is 0 for the whole event, so a trigger is taken only when idle.
- R12: A cyclic chain cannot hang the generator. The number of hops per pass is bounded by the table depth, and a pass that emits nothing ends the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Miss event present |
| trig_ready | output | 1 | Generator idle, event will be taken |
| trig_idx | input | IDX_W | Table index of the missing stream |
| trig_time | input | TIME_W | Miss-counter value of the current miss |
| tbl_idx | output | IDX_W | Table entry being read |
| tbl_addr | input | ADDR_W | Entry's last block address |
| tbl_stride | input | ADDR_W | Entry's stride |
| tbl_conf | input | 2 | Entry's confidence counter |
| tbl_class | input | 2 | Interval class: 0 short, 1 medium, 2 long, 3 very-long |
| tbl_time | input | TIME_W | Miss time of the entry's last access |
| tbl_next | input | IDX_W | Next stream in time order |
| tbl_next_ok | input | 1 | Link valid |
| pf_valid | output | 1 | Prefetch address valid |
| pf_ready | input | 1 | Consumer accepts the address |
| pf_addr | output | ADDR_W | Prefetch block address |
| done | output | 1 | One-cycle pulse at end of event |

## Verification
Four rules are checked by the assertions on every cycle: the handshake holding its address under back-pressure, the per-event emission count never exceeding the degree, the idle-only acceptance of triggers, and the shape of the done pulse. Several behaviours can only be shown by the bench's scenarios, each of which compares the exact address sequence: the per-class quotas, the skip on a short stream's first visit, the recency window at its 20/21 boundary, the wrap back to the triggering stream with resumed offsets, and the termination on a cyclic chain.

// File: rtl/dwpf_pkg.sv
package dwpf_pkg;
    typedef enum logic [1:0] {
        GAP_SHORT = 2'd0,
        GAP_MED   = 2'd1,
        GAP_LONG  = 2'd2,
        GAP_VLONG = 2'd3
    } gap_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_LOOK = 3'd1,
        S_EMIT = 3'd2,
        S_STEP = 3'd3,
        S_DONE = 3'd4
    } st_e;
endpackage

// File: rtl/dwpf_quota.sv
module dwpf_quota #(
    parameter int DEGREE = 8,
    parameter int CNT_W  = $clog2(DEGREE + 1)
) (
    input  logic [1:0]       gap_class,
    input  logic             first_visit,
    input  logic [CNT_W-1:0] budget,
    output logic [CNT_W-1:0] quota,
    output logic             skip_en
);
    import dwpf_pkg::*;

    localparam int Q_MED  = (DEGREE / 2 > 0) ? DEGREE / 2 : 1;
    localparam int Q_LONG = (DEGREE / 4 > 0) ? DEGREE / 4 : 1;

    logic [CNT_W-1:0] raw;

    always_comb begin
        case (gap_e'(gap_class))
            GAP_SHORT: raw = budget;
            GAP_MED:   raw = CNT_W'(Q_MED);
            GAP_LONG:  raw = CNT_W'(Q_LONG);
            default:   raw = CNT_W'(1);
        endcase
        quota   = (raw < budget) ? raw : budget;
        skip_en = (gap_e'(gap_class) == GAP_SHORT) && first_visit;
    end
endmodule

// File: rtl/dwpf_gate.sv
module dwpf_gate #(
    parameter int ADDR_W = 32,
    parameter int TIME_W = 16,
    parameter int WINDOW = 20
) (
    input  logic [1:0]        conf,
    input  logic [ADDR_W-1:0] stride,
    input  logic [TIME_W-1:0] now,
    input  logic [TIME_W-1:0] seen,
    input  logic              exempt,
    output logic              trained,
    output logic              eligible
);
    logic [TIME_W-1:0] age;

    always_comb begin
        age      = now - seen;
        trained  = (conf >= 2'd2) && (stride != '0);
        eligible = trained && (exempt || (age <= TIME_W'(WINDOW)));
    end
endmodule

// File: rtl/dw_prefetch_gen.sv
module dw_prefetch_gen #(
    parameter int ADDR_W = 32,
    parameter int TIME_W = 16,
    parameter int IDX_W  = 3,
    parameter int DEGREE = 8,
    parameter int SKIP   = 2,
    parameter int WINDOW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    output logic              trig_ready,
    input  logic [IDX_W-1:0]  trig_idx,
    input  logic [TIME_W-1:0] trig_time,
    output logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [ADDR_W-1:0] tbl_stride,
    input  logic [1:0]        tbl_conf,
    input  logic [1:0]        tbl_class,
    input  logic [TIME_W-1:0] tbl_time,
    input  logic [IDX_W-1:0]  tbl_next,
    input  logic              tbl_next_ok,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              done
);
    import dwpf_pkg::*;

    localparam int DEPTH = 2 ** IDX_W;
    localparam int CNT_W = $clog2(DEGREE + 1);
    localparam int OFF_W = $clog2(SKIP + DEGREE + 2);
    localparam int HOP_W = $clog2(DEPTH + 1);

    typedef struct packed {
        st_e                         st;
        logic [IDX_W-1:0]            first;
        logic [IDX_W-1:0]            cur;
        logic [TIME_W-1:0]           now;
        logic [CNT_W-1:0]            budget;
        logic [CNT_W-1:0]            cnt;
        logic [HOP_W-1:0]            hops;
        logic                        contrib;
        logic                        opening;
        logic [ADDR_W-1:0]           addr;
        logic [ADDR_W-1:0]           stride;
        logic [IDX_W-1:0]            nxt;
        logic                        nxt_ok;
        logic [DEPTH-1:0]            visited;
        logic [DEPTH-1:0][OFF_W-1:0] off;
    } gen_t;

    gen_t r_q, r_d;

    logic             trained, eligible, skip_en;
    logic [CNT_W-1:0] quota;
    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] k_first;

    dwpf_gate #(.ADDR_W(ADDR_W), .TIME_W(TIME_W), .WINDOW(WINDOW)) u_gate (
        .conf     (tbl_conf),
        .stride   (tbl_stride),
        .now      (r_q.now),
        .seen     (tbl_time),
        .exempt   (r_q.cur == r_q.first),
        .trained  (trained),
        .eligible (eligible)
    );

    dwpf_quota #(.DEGREE(DEGREE), .CNT_W(CNT_W)) u_quota (
        .gap_class   (tbl_class),
        .first_visit (!r_q.visited[r_q.cur]),
        .budget      (r_q.budget),
        .quota       (quota),
        .skip_en     (skip_en)
    );

    always_comb begin
        r_d       = r_q;
        start_off = skip_en ? OFF_W'(SKIP) : r_q.off[r_q.cur];
        k_first   = start_off + 1'b1;
        case (r_q.st)
            S_IDLE: begin
                if (trig_valid) begin
                    r_d.st      = S_LOOK;
                    r_d.first   = trig_idx;
                    r_d.cur     = trig_idx;
                    r_d.now     = trig_time;
                    r_d.budget  = CNT_W'(DEGREE);
                    r_d.hops    = '0;
                    r_d.contrib = 1'b0;
                    r_d.opening = 1'b1;
                    r_d.visited = '0;
                    r_d.off     = '0;
                end
            end
            S_LOOK: begin
                r_d.opening = 1'b0;
                r_d.nxt     = tbl_next;
                r_d.nxt_ok  = tbl_next_ok;
                if (r_q.opening && !trained) begin
                    r_d.st = S_DONE;
                end else if (eligible) begin
                    r_d.addr             = tbl_addr + ADDR_W'(k_first) * tbl_stride;
                    r_d.stride           = tbl_stride;
                    r_d.cnt              = quota;
                    r_d.off[r_q.cur]     = start_off;
                    r_d.visited[r_q.cur] = 1'b1;
                    r_d.st               = S_EMIT;
                end else begin
                    r_d.st = S_STEP;
                end
            end
            S_EMIT: begin
                if (pf_ready) begin
                    r_d.addr         = r_q.addr + r_q.stride;
                    r_d.cnt          = r_q.cnt - 1'b1;
                    r_d.budget       = r_q.budget - 1'b1;
                    r_d.off[r_q.cur] = r_q.off[r_q.cur] + 1'b1;
                    r_d.contrib      = 1'b1;
                    if (r_q.cnt == CNT_W'(1)) r_d.st = S_STEP;
                end
            end
            S_STEP: begin
                if (r_q.budget == '0) begin
                    r_d.st = S_DONE;
                end else if (r_q.nxt_ok && (r_q.hops < HOP_W'(DEPTH))) begin
                    r_d.cur  = r_q.nxt;
                    r_d.hops = r_q.hops + 1'b1;
                    r_d.st   = S_LOOK;
                end else if (!r_q.contrib) begin
                    r_d.st = S_DONE;
                end else begin
                    r_d.cur     = r_q.first;
                    r_d.hops    = '0;
                    r_d.contrib = 1'b0;
                    r_d.st      = S_LOOK;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign trig_ready = (r_q.st == S_IDLE);
    assign pf_valid   = (r_q.st == S_EMIT);
    assign pf_addr    = r_q.addr;
    assign done       = (r_q.st == S_DONE);
    assign tbl_idx    = r_q.cur;
endmodule

// File: rtl/dwpf_chk.sv
module dwpf_chk #(
    parameter int ADDR_W = 32,
    parameter int DEGREE = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_valid,
    input logic              trig_ready,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              done
);
    localparam int EC_W = $clog2(DEGREE + 2);
    logic [EC_W-1:0] emitted;

    always_ff @(posedge clk) begin
        if (!rst_n)                       emitted <= '0;
        else if (trig_valid && trig_ready) emitted <= '0;
        else if (pf_valid && pf_ready)     emitted <= emitted + 1'b1;
    end

    // R10
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    // R2
    degree_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emitted <= EC_W'(DEGREE));

    // R11
    busy_blocks_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !trig_ready);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && trig_ready);
endmodule

bind dw_prefetch_gen dwpf_chk #(.ADDR_W(ADDR_W), .DEGREE(DEGREE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_valid (trig_valid),
    .trig_ready (trig_ready),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .done       (done)
);

// File: tb/dw_prefetch_gen_tb.sv
module dw_prefetch_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSCN = 6;
    localparam int NEXP = 40;

    // expected address list, scenarios back to back
    localparam logic [31:0] EXP [NEXP] = '{
        32'h10C0, 32'h1100, 32'h1140, 32'h1180, 32'h11C0, 32'h1200, 32'h1240, 32'h1280,
        32'h2010, 32'h2020, 32'h2030, 32'h2040, 32'h2050, 32'h2060, 32'h2070, 32'h2080,
        32'h3008, 32'h3010, 32'h4100, 32'h3018, 32'h3020, 32'h4200, 32'h3028, 32'h3030,
        32'h6020, 32'h7001, 32'h6040, 32'h7002, 32'h6060, 32'h7003, 32'h6080, 32'h7004,
        32'h6020, 32'h6040, 32'h6060, 32'h6080, 32'h60A0, 32'h60C0, 32'h60E0, 32'h6100};
    localparam int NCNT [NSCN] = '{8, 8, 8, 0, 8, 8};
    localparam int TIDX [NSCN] = '{0, 1, 2, 5, 6, 6};
    localparam int STALL[NSCN] = '{0, 0, 1, 0, 1, 0};

    logic clk = 0, rst_n = 0;
    logic trig_valid = 0, pf_ready = 1;
    logic [2:0] trig_idx = 0;
    logic [15:0] trig_time = 0;
    logic trig_ready, pf_valid, done, tbl_next_ok;
    logic [2:0] tbl_idx, tbl_next;
    logic [31:0] tbl_addr, tbl_stride, pf_addr;
    logic [1:0] tbl_conf, tbl_class;
    logic [15:0] tbl_time;

    logic [31:0] t_addr [8];
    logic [31:0] t_stride [8];
    logic [1:0]  t_conf [8];
    logic [1:0]  t_class [8];
    logic [15:0] t_time [8];
    logic [2:0]  t_next [8];
    logic        t_nok [8];

    assign tbl_addr    = t_addr[tbl_idx];
    assign tbl_stride  = t_stride[tbl_idx];
    assign tbl_conf    = t_conf[tbl_idx];
    assign tbl_class   = t_class[tbl_idx];
    assign tbl_time    = t_time[tbl_idx];
    assign tbl_next    = t_next[tbl_idx];
    assign tbl_next_ok = t_nok[tbl_idx];

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dw_prefetch_gen u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag(input int s);
        case (s)
            0: return "R3/R8 short skip";
            1: return "R4/R7 medium wrap";
            2: return "R5/R6 long+vlong chain";
            3: return "R9 untrained trigger";
            4: return "R6/R12 age 20 cyclic chain";
            default: return "R6 age 21 excluded";
        endcase
    endfunction

    task automatic put(input int i, input logic [31:0] a, input logic [31:0] s, input logic [1:0] c,
                       input logic [1:0] g, input logic [15:0] t, input logic [2:0] n, input logic nok);
        t_addr[i] = a; t_stride[i] = s; t_conf[i] = c; t_class[i] = g;
        t_time[i] = t; t_next[i] = n; t_nok[i] = nok;
    endtask

    task automatic load_table(input int s);
        for (int i = 0; i < 8; i++) put(i, 0, 0, 0, 0, 0, 0, 0);
        put(0, 32'h1000, 32'h40, 2'd3, 2'd0, 16'd99, 3'd0, 1'b0);
        put(1, 32'h2000, 32'h10, 2'd2, 2'd1, 16'd99, 3'd0, 1'b0);
        put(2, 32'h3000, 32'h08, 2'd3, 2'd2, 16'd99, 3'd3, 1'b1);
        put(3, 32'h4000, 32'h100, 2'd2, 2'd3, 16'd90, 3'd4, 1'b1);
        put(4, 32'h5000, 32'h04, 2'd3, 2'd1, 16'd70, 3'd0, 1'b0);
        put(5, 32'h8000, 32'h40, 2'd1, 2'd0, 16'd99, 3'd0, 1'b0);
        put(6, 32'h6000, 32'h20, 2'd3, 2'd3, 16'd150, 3'd7, 1'b1);
        put(7, 32'h7000, 32'h01, 2'd3, 2'd3, (s == 5) ? 16'd179 : 16'd180, 3'd6, 1'b1);
    endtask

    task automatic run_event(input int s, input int base);
        int got = 0;
        bit stalled = 0, saw_done = 0;
        logic [31:0] held = 0;
        load_table(s);
        @(negedge clk);
        trig_valid = 1; trig_idx = 3'(TIDX[s]); trig_time = (s >= 4) ? 16'd200 : 16'd100;
        @(negedge clk);
        trig_valid = 0;
        for (int c = 0; c < 300 && !saw_done; c++) begin
            pf_ready = (STALL[s] != 0) ? (c % 3 != 2) : 1'b1;
            if (stalled) chk(pf_valid && pf_addr == held, "R10 hold under stall", pf_addr, held);
            stalled = pf_valid && !pf_ready;
            held = pf_addr;
            if (pf_valid && c == 0) chk(!trig_ready, "R11 busy", 32'(trig_ready), 0);
            if (pf_valid && pf_ready) begin
                if (got < NCNT[s])
                    chk(pf_addr == EXP[base + got], tag(s), pf_addr, EXP[base + got]);
                else
                    chk(0, "R2 extra address", pf_addr, 0);
                got++;
            end
            if (done) saw_done = 1;
            @(negedge clk);
        end
        pf_ready = 1;
        chk(saw_done, "R11 done seen", 32'(saw_done), 1);
        chk(got == NCNT[s], {"R2 count ", tag(s)}, 32'(got), 32'(NCNT[s]));
        chk(!done && trig_ready, "R11 idle after done", {30'd0, done, trig_ready}, 32'd1);
    endtask

    initial begin
        int base = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(trig_ready && !pf_valid && !done, "R1 reset state",
            {29'd0, trig_ready, pf_valid, done}, 32'd4);
        for (int s = 0; s < NSCN; s++) begin
            run_event(s, base);
            base += NCNT[s];
        end
        // R9 again, directly after a full event
        run_event(3, 0);
        // R1 reset in mid-event returns to idle
        load_table(0);
        trig_valid = 1; trig_idx = 0; trig_time = 16'd5;
        @(negedge clk); trig_valid = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        chk(trig_ready && !pf_valid && !done, "R1 reset mid-event",
            {29'd0, trig_ready, pf_valid, done}, 32'd4);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule